// File: doc/BRIEF.md
# Programmable Tap Delay Stack

This block holds the last sixteen 12-bit words written to one multiplier operand input. Each word passes through a chain of registers. A new word enters at the head of the chain on every clock edge at which the active-low push input is low. On that same edge the older words each move one place deeper, and the deepest word is lost. When the push input is high, the chain keeps its contents and the incoming word is thrown away.

A 4-bit select picks one stage of the chain, and that stage drives the registered operand output. The select is sampled on every clock edge, whether or not a push happens. Software can therefore use a fixed select to get a delay line of 1 to 16 clocks. It can also hold the push input high and step the select to read the stack as a small addressable store, for example the coefficient and sample banks of a folded FIR filter. A chip that uses this block puts one instance on each of the four multiplier inputs.

Top module: `tap_delay_stack`

## Requirements
- R1: When `rst` is high at a rising clock edge, the edge clears all stages to zero, and `tap_out` reads zero after that edge. With no push afterwards, every select value from 0 to 15 reads zero.
- R2: A rising edge with `push_n` low writes `din` into stage 0. The same edge moves stage k into stage k+1 for k from 0 to 14 and drops the old stage 15.
- R3: A rising edge with `push_n` high leaves every stage unchanged, and the `din` value at that edge is lost. If `dly_sel` does not change either, `tap_out` does not change.
- R4: After each rising edge, `tap_out` equals the stage numbered by the `dly_sel` value sampled at that edge. The stage contents used are those the same edge produces. So a push with select 0 shows the pushed word right after that edge, which is a one-clock delay.
- R5: `dly_sel` is sampled on every edge, whatever the level of `push_n`. With pushes held off, successive edges can read any sequence of stages, and the reads do not disturb the contents.
- R6: With a push on every edge and `dly_sel` held at k, `tap_out` after an edge equals the word pushed k edges earlier. At k = 15 this is the maximum delay: the word pushed sixteen clocks before the output is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| push_n | input | 1 | Active-low push enable |
| din | input | 12 | Operand word offered to the head of the stack |
| dly_sel | input | 4 | Stage select; value k gives a delay of k+1 clocks |
| tap_out | output | 12 | Registered word of the selected stage |

## Verification
A push and a read of the stack can happen on the same clock edge. In that case the read must see the contents after the shift, not before it. The bench triggers this case on every cycle of a sweep in which it pushes while holding the select at each value from 0 to 15 in turn. A bench-side shift model applies the push first and then indexes, which gives the expected word, and so an off-by-one stage shows up as a mismatch. The bench also mixes push edges with hold edges while the select keeps changing, and a full-depth read sweep with pushes held off confirms that the hold edges shifted nothing.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int TAP_WIDTH_DEF = 12;
    localparam int TAP_DEPTH_DEF = 16;

    // Width of a select able to address every stage (at least one bit).
    function automatic int sel_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/tap_shift_store.sv
module tap_shift_store #(
    parameter int WIDTH = tap_pkg::TAP_WIDTH_DEF,
    parameter int DEPTH = tap_pkg::TAP_DEPTH_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    output logic [DEPTH-1:0][WIDTH-1:0]  next_o
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stage;
    } store_t;

    store_t st_d, st_q;

    // Next contents: either cleared, shifted by one with a new head, or held.
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (push) begin
            st_d.stage[0] = din;
            for (int k = 1; k < DEPTH; k++) begin
                st_d.stage[k] = st_q.stage[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // The read path indexes the contents this edge will produce.
    assign next_o = st_d.stage;

endmodule

// File: rtl/tap_read_select.sv
module tap_read_select #(
    parameter int WIDTH = tap_pkg::TAP_WIDTH_DEF,
    parameter int DEPTH = tap_pkg::TAP_DEPTH_DEF,
    parameter int SEL_W = tap_pkg::sel_width(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DEPTH-1:0][WIDTH-1:0]  stages,
    input  logic [SEL_W-1:0]             sel,
    output logic [WIDTH-1:0]             word_o
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } rd_t;

    rd_t              rd_d, rd_q;
    logic [WIDTH-1:0] pick;

    generate
        if ((1 << SEL_W) == DEPTH) begin : g_full_range
            // Every select code names a real stage.
            assign pick = stages[sel];
        end else begin : g_clamped
            // Codes past the last stage read the deepest one.
            always_comb begin
                if (int'(sel) >= DEPTH) begin
                    pick = stages[DEPTH-1];
                end else begin
                    pick = stages[sel];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_d      = rd_q;
        rd_d.word = rst ? '0 : pick;
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign word_o = rd_q.word;

endmodule

// File: rtl/tap_delay_stack.sv
module tap_delay_stack #(
    parameter  int WIDTH = tap_pkg::TAP_WIDTH_DEF,
    parameter  int DEPTH = tap_pkg::TAP_DEPTH_DEF,
    localparam int SEL_W = tap_pkg::sel_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_n,
    input  logic [WIDTH-1:0] din,
    input  logic [SEL_W-1:0] dly_sel,
    output logic [WIDTH-1:0] tap_out
);

    logic                        push;
    logic [DEPTH-1:0][WIDTH-1:0] stage_next;

    assign push = ~push_n;

    tap_shift_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .din    (din),
        .next_o (stage_next)
    );

    tap_read_select #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .SEL_W (SEL_W)
    ) u_read (
        .clk    (clk),
        .rst    (rst),
        .stages (stage_next),
        .sel    (dly_sel),
        .word_o (tap_out)
    );

endmodule

// File: rtl/tap_delay_stack_chk.sv
module tap_delay_stack_chk #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 16,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             push_n,
    input logic [WIDTH-1:0] din,
    input logic [SEL_W-1:0] dly_sel,
    input logic [WIDTH-1:0] tap_out
);

    // R1: a reset edge leaves the output at zero.
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (tap_out == '0));

    // R4: push with select 0 shows the word just pushed.
    assert_sel0_push_R4: assert property (@(posedge clk) disable iff (rst)
        (!push_n && dly_sel == '0) |=> (tap_out == $past(din)));

    // R3: no push and an unchanged select keep the output still.
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (push_n && $stable(dly_sel)) |=> $stable(tap_out));

    // R2: a push moves the word just read one stage deeper.
    assert_shift_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (!push_n && dly_sel != '0 && $past(dly_sel) == SEL_W'(dly_sel - 1'b1))
        |=> (tap_out == $past(tap_out)));

endmodule

bind tap_delay_stack tap_delay_stack_chk #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .SEL_W (SEL_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .push_n  (push_n),
    .din     (din),
    .dly_sel (dly_sel),
    .tap_out (tap_out)
);

// File: tb/sim_tap_delay_stack.sv
module sim_tap_delay_stack;

    localparam int W = 12;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         push_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [3:0]   dly_sel = '0;
    logic [W-1:0] tap_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [W-1:0] mdl [D];

    always #4 clk = ~clk;

    tap_delay_stack u0 (
        .clk     (clk),
        .rst     (rst),
        .push_n  (push_n),
        .din     (din),
        .dly_sel (dly_sel),
        .tap_out (tap_out)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update model at the rising edge, compare after it.
    task automatic tick(input bit r, input bit pn, input logic [W-1:0] d,
                        input logic [3:0] s, input string req);
        @(negedge clk);
        rst = r; push_n = pn; din = d; dly_sel = s;
        @(posedge clk);
        #1;
        if (r) begin
            for (int k = 0; k < D; k++) mdl[k] = '0;
        end else if (!pn) begin
            for (int k = D-1; k > 0; k--) mdl[k] = mdl[k-1];
            mdl[0] = d;
        end
        check(tap_out, r ? '0 : mdl[s], req);
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 37 + 5) ^ (i << 7));
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < D; k++) mdl[k] = '0;
        // R1: reset then read every stage without pushing.
        tick(1'b1, 1'b1, '0, 4'd0, "R1");
        tick(1'b1, 1'b0, 12'hABC, 4'd3, "R1");
        for (int s = 0; s < D; s++) tick(1'b0, 1'b1, 12'hFFF, 4'(s), "R1");

        // R2 R4: fill with a changing select.
        for (int i = 0; i < 40; i++) tick(1'b0, 1'b0, pat(i), 4'(i % D), "R2");

        // R3 R5: hold while sweeping the select both ways with junk on din.
        for (int s = 0; s < D; s++) tick(1'b0, 1'b1, pat(100 + s), 4'(s), "R5");
        for (int s = D-1; s >= 0; s--) tick(1'b0, 1'b1, pat(200 + s), 4'(s), "R3");
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, pat(300 + i), 4'd9, "R3");

        // R4 R6: continuous push with each fixed select (push and read in one edge).
        for (int k = 0; k < D; k++) begin
            for (int i = 0; i < 20; i++) begin
                tick(1'b0, 1'b0, pat(1000 + 20 * k + i), 4'(k), (k == D-1) ? "R6" : "R4");
            end
        end

        // R2 R3: push on every third edge, select walking.
        for (int i = 0; i < 60; i++) begin
            tick(1'b0, (i % 3) != 0, pat(2000 + i), 4'((i * 5) % D), "R2");
        end

        // R1: reset in mid-run clears all stages.
        tick(1'b1, 1'b0, 12'h123, 4'd7, "R1");
        for (int s = 0; s < D; s++) tick(1'b0, 1'b1, 12'h5A5, 4'(s), "R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule